// File: doc/BRIEF.md
# Block Check Sequence Checker

This block sits behind a character-synchronous receive framer. It watches the byte stream the framer delivers and builds a block check over the characters of each block. At the end of the block it states whether the block arrived intact. Three kinds of check can be chosen:
- a 16-bit cyclic redundancy check;
- an 8-bit longitudinal XOR check;
- a per-character vertical parity check.

The framer marks the first and last byte of each block. It also flags filler bytes that must not count towards the check. These are idle sync characters, and both bytes of an escaped sync pair in transparent operation. The block skips every flagged byte.

At the start of each block the accumulator is loaded with either all ones or all zeros. The check type and the parity sense are taken when the block opens and held until it closes. For both accumulating check types the check bytes themselves are fed through the accumulator. An intact block therefore leaves a zero residue. One cycle after the block closes, the block gives a single-cycle status strobe together with a pass/fail bit.

Top module: `blkchk_top`

## Requirements
- R1: While reset is asserted and after its release, until a block ends, statValid and statPass are 0.
- R2: With cfgMode = 0, the block uses a 16-bit CRC with reflected polynomial 0xA001 (x^16+x^15+x^2+1). Each included byte is processed LSB first. statPass is 1 exactly when the last two included bytes equal the CRC of the earlier included bytes, low byte first.
- R3: With cfgMode = 1, statPass is 1 exactly when the last included byte equals the 8-bit XOR of the preset's low byte and all earlier included bytes.
- R4: With cfgMode = 2, there is no check byte. statPass is 1 exactly when every included byte has a total count of ones that is odd when cfgOddParity = 1, or even when cfgOddParity = 0.
- R5: The accumulator is preset to all ones when cfgPresetOnes = 1 and to all zeros when it is 0, sampled in the cycle of blkStart.
- R6: A byte strobed with inExclude = 1 has no effect on the result.
- R7: statValid is high for exactly one cycle, in the cycle after the clock edge that samples blkEnd inside a block. statPass is valid in that same cycle.
- R8: Bytes strobed outside a block do not affect the result. A blkEnd outside a block produces no statValid.
- R9: cfgMode and cfgOddParity are sampled with blkStart. cfgMode, cfgOddParity and cfgPresetOnes may change during a block without effect.
- R10: A byte strobed together with blkStart is the first byte of the block. A byte strobed with blkEnd is its last byte. Both may fall in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Check type: 0 CRC16, 1 LRC, 2 VRC (3 acts as LRC) |
| cfgPresetOnes | input | 1 | 1 presets accumulator to all ones, 0 to all zeros |
| cfgOddParity | input | 1 | VRC sense: 1 odd, 0 even |
| inByte | input | 8 | Received character |
| inValid | input | 1 | inByte strobe |
| inExclude | input | 1 | Byte is filler and is skipped |
| blkStart | input | 1 | First byte of a block / open block |
| blkEnd | input | 1 | Last byte of a block / close block |
| statValid | output | 1 | One-cycle block status strobe |
| statPass | output | 1 | Block check result, 1 = pass |

## Verification
The only results are statValid and statPass. Both come from one register stage, so they change at the rising edge that samples blkEnd and hold the status for the following cycle. The bench drives every input on falling edges. It reads the status at the falling edge right after the closing byte, then reads statValid again one falling edge later to confirm that the strobe has dropped. Checks of ignored inputs use the same timing: a stray close must leave statValid low at that falling edge, and stray or flagged bytes must leave the pass result as the arithmetic model predicts.

// File: rtl/blkchk_pkg.sv
package blkchk_pkg;

  typedef enum logic [1:0] {
    CHK_CRC16 = 2'd0,
    CHK_LRC   = 2'd1,
    CHK_VRC   = 2'd2,
    CHK_SPARE = 2'd3
  } chkMode_e;

  // Strobes from control to datapath, plus the settings held for the block
  typedef struct packed {
    logic     preset;
    logic     take;
    logic     finish;
    chkMode_e mode;
    logic     oddPar;
  } dpCmd_t;

endpackage

// File: rtl/blkchk_ctrl.sv
module blkchk_ctrl
  import blkchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgMode,
  input  logic       cfgOddParity,
  input  logic       inValid,
  input  logic       inExclude,
  input  logic       blkStart,
  input  logic       blkEnd,
  output dpCmd_t     cmd,
  output logic       inBlock
);

  chkMode_e modeQ;
  logic     oddQ;
  logic     active;
  logic     inBlockNext;

  // A block is live in its opening cycle and until the closing cycle
  assign active = blkStart | inBlock;

  always_comb begin
    cmd.preset = blkStart;
    cmd.take   = active & inValid & ~inExclude;
    cmd.finish = active & blkEnd;
    cmd.mode   = blkStart ? chkMode_e'(cfgMode) : modeQ;
    cmd.oddPar = blkStart ? cfgOddParity : oddQ;
  end

  always_comb begin
    inBlockNext = inBlock;
    if (cmd.finish)    inBlockNext = 1'b0;
    else if (blkStart) inBlockNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBlock <= 1'b0;
      modeQ   <= CHK_CRC16;
      oddQ    <= 1'b1;
    end else begin
      inBlock <= inBlockNext;
      if (blkStart) begin
        modeQ <= chkMode_e'(cfgMode);
        oddQ  <= cfgOddParity;
      end
    end
  end

  p_start_opens_r10: assert property (@(posedge clk) disable iff (!rstN)
    (blkStart && !blkEnd) |=> inBlock);

  p_end_closes_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.finish |=> !inBlock);

  p_mode_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inBlock && !blkStart) |=> $stable(modeQ) && $stable(oddQ));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!inBlock && !blkStart) |-> (!cmd.take && !cmd.finish));

endmodule

// File: rtl/blkchk_datapath.sv
module blkchk_datapath
  import blkchk_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'hA001
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              presetOnes,
  input  logic [BYTE_W-1:0] inByte,
  output logic              statValid,
  output logic              statPass
);

  localparam int LRC_W = BYTE_W;

  logic [CRC_W-1:0] acc;
  logic [CRC_W-1:0] accBase;
  logic [CRC_W-1:0] accNext;
  logic [CRC_W-1:0] presetVal;
  logic             parErr;
  logic             parBase;
  logic             parNext;
  logic             charBad;
  logic             passNow;
  logic [CRC_W-1:0] crcStage [BYTE_W+1];

  assign presetVal = presetOnes ? {CRC_W{1'b1}} : {CRC_W{1'b0}};
  assign accBase   = cmd.preset ? presetVal : acc;
  assign parBase   = cmd.preset ? 1'b0 : parErr;

  // One shift stage per input bit, least significant bit first
  assign crcStage[0] = accBase;
  for (genvar i = 0; i < BYTE_W; i++) begin : g_crcBit
    assign crcStage[i+1] = (crcStage[i][0] ^ inByte[i])
                         ? ((crcStage[i] >> 1) ^ CRC_POLY)
                         : (crcStage[i] >> 1);
  end

  assign charBad = (^inByte) != cmd.oddPar;
  assign parNext = parBase | (cmd.take & charBad);

  always_comb begin
    accNext = accBase;
    if (cmd.take) begin
      if (cmd.mode == CHK_CRC16)
        accNext = crcStage[BYTE_W];
      else
        accNext = {accBase[CRC_W-1:LRC_W], accBase[LRC_W-1:0] ^ inByte};
    end
  end

  always_comb begin
    case (cmd.mode)
      CHK_CRC16: passNow = (accNext == '0);
      CHK_VRC:   passNow = ~parNext;
      default:   passNow = (accNext[LRC_W-1:0] == '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      parErr    <= 1'b0;
      statValid <= 1'b0;
      statPass  <= 1'b0;
    end else begin
      acc       <= accNext;
      parErr    <= parNext;
      statValid <= cmd.finish;
      if (cmd.finish) statPass <= passNow;
    end
  end

  p_status_after_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.finish |=> statValid);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.finish |=> !statValid);

  p_preset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.preset && !cmd.take) |=> (acc == $past(presetVal)));

  p_skip_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.take && !cmd.preset) |=> $stable(acc));

  p_parity_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (parErr && !cmd.preset) |=> parErr);

endmodule

// File: rtl/blkchk_top.sv
module blkchk_top
  import blkchk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'hA001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic              cfgPresetOnes,
  input  logic              cfgOddParity,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inValid,
  input  logic              inExclude,
  input  logic              blkStart,
  input  logic              blkEnd,
  output logic              statValid,
  output logic              statPass
);

  dpCmd_t cmd;
  logic   inBlock;

  blkchk_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgMode      (cfgMode),
    .cfgOddParity (cfgOddParity),
    .inValid      (inValid),
    .inExclude    (inExclude),
    .blkStart     (blkStart),
    .blkEnd       (blkEnd),
    .cmd          (cmd),
    .inBlock      (inBlock)
  );

  blkchk_datapath #(
    .BYTE_W   (BYTE_W),
    .CRC_W    (CRC_W),
    .CRC_POLY (CRC_POLY)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .presetOnes (cfgPresetOnes),
    .inByte     (inByte),
    .statValid  (statValid),
    .statPass   (statPass)
  );

  p_no_status_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!inBlock && !blkStart) |=> !statValid);

endmodule

// File: tb/test_blkchk_top.sv
`timescale 1ns/1ps
module test_blkchk_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] cfgMode;
  logic       cfgPresetOnes;
  logic       cfgOddParity;
  logic [7:0] inByte;
  logic       inValid;
  logic       inExclude;
  logic       blkStart;
  logic       blkEnd;
  logic       statValid;
  logic       statPass;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  blkchk_top i_blkchk_top (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgPresetOnes(cfgPresetOnes),
    .cfgOddParity(cfgOddParity), .inByte(inByte), .inValid(inValid),
    .inExclude(inExclude), .blkStart(blkStart), .blkEnd(blkEnd),
    .statValid(statValid), .statPass(statPass)
  );

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [15:0] crcUpd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; inExclude = 1'b0; blkStart = 1'b0; blkEnd = 1'b0; inByte = 8'h00;
  endtask

  // One block: stray byte before it (R8), filler bytes inside (R6),
  // optional settings change after the opening byte (R9).
  task automatic runBlock(input int mode, input bit pre, input bit odd, input int n,
                          input bit corrupt, input bit wrongPre, input bit swap);
    logic [7:0]  msg [0:15];
    int          len = 0;
    logic [15:0] c;
    logic [7:0]  l;
    logic [31:0] r;
    bit          expPass;
    string       tag;
    tag = (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
    for (int k = 0; k < n; k++) begin
      r = nextRand();
      if (mode == 2) msg[len] = {odd ^ (^r[6:0]), r[6:0]};
      else           msg[len] = r[7:0];
      len++;
    end
    if (mode == 0) begin
      c = (pre ^ wrongPre) ? 16'hFFFF : 16'h0000;
      for (int k = 0; k < n; k++) c = crcUpd(c, msg[k]);
      msg[len] = c[7:0]; msg[len+1] = c[15:8]; len += 2;
    end else if (mode == 1) begin
      l = (pre ^ wrongPre) ? 8'hFF : 8'h00;
      for (int k = 0; k < n; k++) l = l ^ msg[k];
      msg[len] = l; len++;
    end
    if (corrupt) msg[n/2] = msg[n/2] ^ 8'h04;
    expPass = !corrupt && !wrongPre;

    @(negedge clk);
    cfgMode = mode[1:0]; cfgPresetOnes = pre; cfgOddParity = odd;
    r = nextRand();
    inValid = 1'b1; inExclude = 1'b0; inByte = r[7:0]; blkStart = 1'b0; blkEnd = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (i > 0 && i % 3 == 0) begin
        @(negedge clk);
        r = nextRand();
        inValid = 1'b1; inExclude = 1'b1; inByte = r[7:0] | 8'h01;
        blkStart = 1'b0; blkEnd = 1'b0;
      end
      @(negedge clk);
      if (swap && i == 1) begin
        cfgMode = 2'((mode + 1) % 3); cfgOddParity = !odd; cfgPresetOnes = !pre;
      end
      inValid = 1'b1; inExclude = 1'b0; inByte = msg[i];
      blkStart = (i == 0); blkEnd = (i == len - 1);
    end
    idle();
    chk(statValid === 1'b1, "R7", statValid, 1);
    chk(statPass === expPass, swap ? {tag, "/R9"} : tag, statPass, expPass);
    idle();
    chk(statValid === 1'b0, "R7", statValid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgMode = 2'd0; cfgPresetOnes = 1'b0; cfgOddParity = 1'b1;
    inByte = 8'h00; inValid = 1'b0; inExclude = 1'b0; blkStart = 1'b0; blkEnd = 1'b0;
    repeat (3) @(negedge clk);
    chk(statValid === 1'b0, "R1", statValid, 0);
    chk(statPass === 1'b0, "R1", statPass, 0);
    rstN = 1'b1;
    idle(); idle();
    chk(statValid === 1'b0, "R1", statValid, 0);
    chk(statPass === 1'b0, "R1", statPass, 0);

    // R8: close without an open block
    @(negedge clk);
    blkEnd = 1'b1; inValid = 1'b1; inByte = 8'h5A;
    idle();
    chk(statValid === 1'b0, "R8", statValid, 0);

    // Sweep: check type, preset (R5), parity sense, length (R10 at n=1),
    // intact or damaged, steady or changed settings (R9)
    for (int sw = 0; sw < 2; sw++)
      for (int m = 0; m < 3; m++)
        for (int p = 0; p < 2; p++)
          for (int o = 0; o < 2; o++)
            for (int ni = 0; ni < 4; ni++)
              for (int cr = 0; cr < 2; cr++)
                runBlock(m, p[0], o[0], (ni == 0) ? 1 : (ni == 1) ? 2 : (ni == 2) ? 5 : 9,
                         cr[0], 1'b0, sw[0]);

    // R5: check bytes built from the other preset must fail
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++)
        for (int ni = 1; ni < 6; ni++)
          runBlock(m, p[0], 1'b1, ni, 1'b0, 1'b1, 1'b0);

    // R8: close again after blocks, no block open
    @(negedge clk);
    blkEnd = 1'b1;
    idle();
    chk(statValid === 1'b0, "R8", statValid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule